// File: doc/BRIEF.md
# Four-Mode Timer/Counter Pair

This block holds two counter channels of the kind found beside a small microcontroller core. One configuration byte selects, for each channel, whether a pin-level gate qualifies counting, whether counts come from machine cycles or from falling edges on an external count pin, and which of four counting structures the channel uses. A control word carries one run bit and one overflow flag per channel. Software can read and write every count byte.

All counting advances only on cycles where the machine-cycle strobe is high. The external count pins are sampled once per machine cycle, so a falling edge needs two machine cycles to register. The four structures are:
- a 13-bit counter whose low five bits act as a prescaler under an 8-bit count;
- a plain 16-bit counter;
- an 8-bit counter that refills itself from the other byte on rollover;
- a split arrangement in which channel 0 becomes two independent byte timers and channel 1 freezes.

The external count and gate pins are assumed to be already synchronous to `clk`.

Top module: `tmr_pair`

## Requirements
- R1: After a synchronous active-low reset, both 16-bit counts, the configuration byte, both run bits and both overflow flags read zero.
- R2: The configuration byte holds channel 0 in bits 3:0 and channel 1 in bits 7:4. Within each nibble:
  - bit 3 is the gate enable;
  - bit 2 selects the source (1 = count pin);
  - bits 1:0 are the mode.
  
  With source 0, the channel takes one count per cycle with `mc_tick` high and none on other cycles.
- R3: With source 1, the channel counts once on a `mc_tick` cycle where the pin sample taken at the previous `mc_tick` was 1 and the pin now reads 0. Pin samples are taken only on `mc_tick` cycles.
- R4: A channel counts only while its run bit is 1 and either its gate enable is 0 or its `gate_pin` is 1.
- R5: In mode 0, count bits 4:0 and 15:8 form one 13-bit counter, and bits 7:5 hold their value. The channel's overflow flag sets when all 13 bits roll from ones to zero.
- R6: In mode 1, the 16-bit count increments and sets the channel's overflow flag when it rolls from 16'hFFFF to 0.
- R7: In mode 2, the low byte increments. When it is 8'hFF, the next count loads the high byte into the low byte instead and sets the overflow flag.
- R8: In mode 3, channel 0's low byte counts under channel 0's run, gate and source controls and sets flag 0. Channel 0's high byte counts every `mc_tick` while run bit 1 is set, ignoring gate and source, and its rollover sets flag 1.
- R9: A channel 1 configured for mode 3 holds its count. While channel 0 is in mode 3, channel 1 still counts in its own mode, but its rollovers do not set flag 1.
- R10: When `cnt_we` is high, `cnt_sel` picks the byte to write: bit 1 is the channel and bit 0 selects the high byte. That byte takes `cnt_wdata`, and the channel's counting is cancelled for that cycle.
- R11: `ctl_wdata` bit 0 is run 0, bit 1 is run 1, bit 2 is flag 0 and bit 3 is flag 1. A control write loads all four bits. A hardware overflow in the same cycle still leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| cnt_pin | input | 2 | External count pins, index = channel |
| gate_pin | input | 2 | External gate pins, index = channel |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte value |
| ctl_we | input | 1 | Write strobe for run bits and flags |
| ctl_wdata | input | 4 | Run and flag values |
| cnt_we | input | 1 | Write strobe for one count byte |
| cnt_sel | input | 2 | Count byte select {channel, high} |
| cnt_wdata | input | 8 | Count byte value |
| cfg_q | output | 8 | Configuration byte |
| run_q | output | 2 | Run bits |
| ovf_q | output | 2 | Overflow flags |
| cnt0_q | output | 16 | Channel 0 count {high, low} |
| cnt1_q | output | 16 | Channel 1 count {high, low} |

## Verification
A wrong count structure or a wrong enable shows on `cnt0_q` or `cnt1_q` within the first qualified machine cycle after it arises, because every count is compared against the expected value once per clock. A stale pin sample shows as one missing or extra count at the next `mc_tick`. A misrouted rollover shows on `ovf_q` one clock after the wrapping count. In reload mode, a wrong refill value appears in the low byte in that same clock.

// File: rtl/tmr_pkg.sv
// Shared types for the timer/counter pair.
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_PRE13  = 2'b00,
        MODE_WIDE16 = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_SPLIT  = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      gate_en;
        logic      ext_src;
        tmr_mode_e mode;
    } chan_cfg_t;
endpackage

// File: rtl/tmr_event.sv
// Count qualifier for one channel: samples the count pin on each machine
// cycle and emits a one-clock count event when run, gate and source agree.
// Assumes the pins are synchronous to clk.
module tmr_event (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic gate_en,
    input  logic ext_src,
    input  logic pin,
    input  logic gate_pin,
    output logic ev
);
    logic samp_q;
    logic fall;

    // Keep the pin level seen at the last machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    samp_q <= 1'b0;
        else if (tick) samp_q <= pin;
    end

    // Combine source, run and gate into a single count event.
    always_comb begin
        fall = samp_q & ~pin;
        ev   = tick & run & (~gate_en | gate_pin) & (ext_src ? fall : 1'b1);
    end

    // R4: with the gate closed no event may appear.
    p_gate_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !gate_pin) |-> !ev);
endmodule

// File: rtl/tmr_chan.sv
// One channel's count bytes and the four counting structures. SPLIT_OK
// enables the split mode's two byte timers; without it split mode holds.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int BW       = 8,
    parameter int PRE_W    = 5,
    parameter bit SPLIT_OK = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  tmr_mode_e       mode,
    input  logic            ev,
    input  logic            aux_ev,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [BW-1:0]   wdata,
    output logic [2*BW-1:0] cnt_q,
    output logic            ovf_p,
    output logic            ovf_a
);
    localparam int PW = BW + PRE_W;

    logic [BW-1:0] lo_q, hi_q, lo_n, hi_n;
    logic [PW-1:0] pre_sum;

    assign cnt_q = {hi_q, lo_q};

    // Next-state for both bytes and the overflow pulses.
    always_comb begin
        lo_n    = lo_q;
        hi_n    = hi_q;
        ovf_p   = 1'b0;
        ovf_a   = 1'b0;
        pre_sum = {hi_q, lo_q[PRE_W-1:0]} + PW'(1);
        if (wr_lo || wr_hi) begin
            if (wr_lo) lo_n = wdata;
            if (wr_hi) hi_n = wdata;
        end else begin
            case (mode)
                MODE_PRE13: if (ev) begin
                    ovf_p              = &{hi_q, lo_q[PRE_W-1:0]};
                    lo_n[PRE_W-1:0]    = pre_sum[PRE_W-1:0];
                    hi_n               = pre_sum[PW-1:PRE_W];
                end
                MODE_WIDE16: if (ev) begin
                    ovf_p        = &{hi_q, lo_q};
                    {hi_n, lo_n} = {hi_q, lo_q} + (2*BW)'(1);
                end
                MODE_RELOAD: if (ev) begin
                    if (&lo_q) begin
                        lo_n  = hi_q;
                        ovf_p = 1'b1;
                    end else begin
                        lo_n = lo_q + BW'(1);
                    end
                end
                default: if (SPLIT_OK) begin
                    if (ev) begin
                        ovf_p = &lo_q;
                        lo_n  = lo_q + BW'(1);
                    end
                    if (aux_ev) begin
                        ovf_a = &hi_q;
                        hi_n  = hi_q + BW'(1);
                    end
                end
            endcase
        end
    end

    // Count byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    // R7: a reload rollover copies the high byte into the low byte.
    p_reload_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RELOAD && ovf_p) |=> lo_q == $past(hi_q));
    // R5: the high byte waits until the prescaler wraps.
    p_prescale_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PRE13 && ev && !wr_lo && !wr_hi && !(&lo_q[PRE_W-1:0]))
        |=> $stable(hi_q));
    // R9: a channel without split support freezes in split mode.
    p_split_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!SPLIT_OK && mode == MODE_SPLIT && !wr_lo && !wr_hi) |=> $stable(cnt_q));
    // R2: without any event or write the count holds.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev && !aux_ev && !wr_lo && !wr_hi) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_pair.sv
// Two timer/counter channels with a shared configuration byte and a
// control word of run bits and overflow flags. Inputs are assumed
// synchronous to clk; mc_tick is one clock wide per machine cycle.
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int BW    = 8,
    parameter int PRE_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mc_tick,
    input  logic [1:0]      cnt_pin,
    input  logic [1:0]      gate_pin,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_wdata,
    input  logic            ctl_we,
    input  logic [3:0]      ctl_wdata,
    input  logic            cnt_we,
    input  logic [1:0]      cnt_sel,
    input  logic [BW-1:0]   cnt_wdata,
    output logic [7:0]      cfg_q,
    output logic [1:0]      run_q,
    output logic [1:0]      ovf_q,
    output logic [2*BW-1:0] cnt0_q,
    output logic [2*BW-1:0] cnt1_q
);
    localparam int NCH = 2;

    chan_cfg_t       ccfg [NCH];
    logic [NCH-1:0]  ev, ovf_p, ovf_a, wr_lo, wr_hi, flag_set;
    logic [2*BW-1:0] cnt [NCH];
    logic            aux_ev;
    logic            ch0_split;

    // Configuration byte and control word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            run_q <= '0;
            ovf_q <= '0;
        end else begin
            if (cfg_we) cfg_q <= cfg_wdata;
            if (ctl_we) run_q <= ctl_wdata[1:0];
            ovf_q <= (ctl_we ? ctl_wdata[3:2] : ovf_q) | flag_set;
        end
    end

    // Route flags: the split high byte takes over channel 1's flag.
    always_comb begin
        ch0_split   = (ccfg[0].mode == MODE_SPLIT);
        aux_ev      = mc_tick & run_q[1];
        flag_set[0] = ovf_p[0];
        flag_set[1] = ch0_split ? ovf_a[0] : ovf_p[1];
    end

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            assign ccfg[k]  = chan_cfg_t'(cfg_q[4*k +: 4]);
            assign wr_lo[k] = cnt_we && cnt_sel == {1'(k), 1'b0};
            assign wr_hi[k] = cnt_we && cnt_sel == {1'(k), 1'b1};

            tmr_event i_event (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (mc_tick),
                .run      (run_q[k]),
                .gate_en  (ccfg[k].gate_en),
                .ext_src  (ccfg[k].ext_src),
                .pin      (cnt_pin[k]),
                .gate_pin (gate_pin[k]),
                .ev       (ev[k])
            );

            tmr_chan #(
                .BW       (BW),
                .PRE_W    (PRE_W),
                .SPLIT_OK (k == 0)
            ) i_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .mode   (ccfg[k].mode),
                .ev     (ev[k]),
                .aux_ev (aux_ev),
                .wr_lo  (wr_lo[k]),
                .wr_hi  (wr_hi[k]),
                .wdata  (cnt_wdata),
                .cnt_q  (cnt[k]),
                .ovf_p  (ovf_p[k]),
                .ovf_a  (ovf_a[k])
            );
        end
    endgenerate

    assign cnt0_q = cnt[0];
    assign cnt1_q = cnt[1];

    // R10: a byte write lands regardless of counting.
    p_wr_lo0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && cnt_sel == 2'd0) |=> cnt0_q[BW-1:0] == $past(cnt_wdata));
    p_wr_hi0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && cnt_sel == 2'd1) |=> cnt0_q[2*BW-1:BW] == $past(cnt_wdata));
    p_wr_lo1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && cnt_sel == 2'd2) |=> cnt1_q[BW-1:0] == $past(cnt_wdata));
    p_wr_hi1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && cnt_sel == 2'd3) |=> cnt1_q[2*BW-1:BW] == $past(cnt_wdata));
    // R11: a hardware overflow always leaves its flag set.
    p_flag0_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_p[0] |=> ovf_q[0]);
    // R8: the split high byte's rollover sets flag 1.
    p_split_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_split && ovf_a[0]) |=> ovf_q[1]);
    // R9: channel 1 rollovers are muted while channel 0 is split.
    p_muted_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_split && !ovf_a[0] && !ctl_we && !ovf_q[1]) |=> !ovf_q[1]);
endmodule

// File: tb/test_tmr_pair.sv
// Self-checking bench: directed phases plus seeded random traffic, each
// cycle compared against a bench model built from the requirements.
module test_tmr_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_tick = 1'b0;
    logic [1:0]  cnt_pin = '0, gate_pin = '0;
    logic        cfg_we = 1'b0, ctl_we = 1'b0, cnt_we = 1'b0;
    logic [7:0]  cfg_wdata = '0, cnt_wdata = '0;
    logic [3:0]  ctl_wdata = '0;
    logic [1:0]  cnt_sel = '0;
    logic [7:0]  cfg_q;
    logic [1:0]  run_q, ovf_q;
    logic [15:0] cnt0_q, cnt1_q;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    string tag = "R1";

    logic [7:0]  m_cfg = '0;
    logic [1:0]  m_run = '0, m_ovf = '0, m_samp = '0;
    logic [15:0] m_c0 = '0, m_c1 = '0;

    always #2 clk = ~clk;

    tmr_pair i_tmr_pair (
        .clk, .rst_n, .mc_tick, .cnt_pin, .gate_pin,
        .cfg_we, .cfg_wdata, .ctl_we, .ctl_wdata,
        .cnt_we, .cnt_sel, .cnt_wdata,
        .cfg_q, .run_q, .ovf_q, .cnt0_q, .cnt1_q
    );

    // Expected next state of one channel.
    task automatic chan_step(input logic [15:0] c, input logic [1:0] md,
                             input logic en, input logic aux, input logic wl,
                             input logic wh, input logic sp, input logic [7:0] wd,
                             output logic [15:0] n, output logic op, output logic oa);
        logic [12:0] s;
        n = c; op = 1'b0; oa = 1'b0;
        s = {c[15:8], c[4:0]} + 13'd1;
        if (wl || wh) begin
            if (wl) n[7:0]  = wd;
            if (wh) n[15:8] = wd;
        end else begin
            case (md)
                2'd0: if (en) begin op = (c[15:8] == 8'hFF) && (c[4:0] == 5'h1F);
                                    n[15:8] = s[12:5]; n[4:0] = s[4:0]; end
                2'd1: if (en) begin op = (c == 16'hFFFF); n = c + 16'd1; end
                2'd2: if (en) begin
                          if (c[7:0] == 8'hFF) begin n[7:0] = c[15:8]; op = 1'b1; end
                          else n[7:0] = c[7:0] + 8'd1;
                      end
                default: if (sp) begin
                          if (en)  begin op = (c[7:0] == 8'hFF);  n[7:0]  = c[7:0] + 8'd1; end
                          if (aux) begin oa = (c[15:8] == 8'hFF); n[15:8] = c[15:8] + 8'd1; end
                      end
            endcase
        end
    endtask

    // Advance the model across one clock using the current inputs.
    task automatic model_step();
        logic [1:0]  en, op, oa;
        logic [15:0] n0, n1;
        logic [3:0]  nb;
        logic        aux;
        for (int k = 0; k < 2; k++) begin
            nb = m_cfg[4*k +: 4];
            en[k] = mc_tick & m_run[k] & (~nb[3] | gate_pin[k]) &
                    (nb[2] ? (m_samp[k] & ~cnt_pin[k]) : 1'b1);
        end
        aux = mc_tick & m_run[1];
        chan_step(m_c0, m_cfg[1:0], en[0], aux, cnt_we && cnt_sel == 2'd0,
                  cnt_we && cnt_sel == 2'd1, 1'b1, cnt_wdata, n0, op[0], oa[0]);
        chan_step(m_c1, m_cfg[5:4], en[1], aux, cnt_we && cnt_sel == 2'd2,
                  cnt_we && cnt_sel == 2'd3, 1'b0, cnt_wdata, n1, op[1], oa[1]);
        m_ovf = (ctl_we ? ctl_wdata[3:2] : m_ovf) |
                {(m_cfg[1:0] == 2'd3) ? oa[0] : op[1], op[0]};
        if (ctl_we) m_run = ctl_wdata[1:0];
        if (mc_tick) m_samp = cnt_pin;
        if (cfg_we) m_cfg = cfg_wdata;
        m_c0 = n0;
        m_c1 = n1;
    endtask

    task automatic check_all();
        logic [45:0] act, exp;
        act = {cfg_q, run_q, ovf_q, cnt0_q, cnt1_q};
        exp = {m_cfg, m_run, m_ovf, m_c0, m_c1};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {cfg,run,ovf,cnt0,cnt1} actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: model, edge, compare at the falling edge, clear strobes.
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
        cfg_we = 1'b0; ctl_we = 1'b0; cnt_we = 1'b0;
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v; mc_tick = 1'b0; cyc();
    endtask
    task automatic wr_ctl(input logic [3:0] v);
        ctl_we = 1'b1; ctl_wdata = v; mc_tick = 1'b0; cyc();
    endtask
    task automatic wr_cnt(input logic [1:0] s, input logic [7:0] v);
        cnt_we = 1'b1; cnt_sel = s; cnt_wdata = v; mc_tick = 1'b0; cyc();
    endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin mc_tick = 1'b1; cyc(); mc_tick = 1'b0; cyc(); end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0: return "R5";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        tag = "R1";
        check_all();
        rst_n = 1'b1;
        cyc();

        tag = "R2";
        wr_cfg(8'h01); wr_ctl(4'b0001);
        ticks(5);
        mc_tick = 1'b0; repeat (3) cyc();

        tag = "R3";
        wr_cfg(8'h05);
        for (int i = 0; i < 8; i++) begin
            cnt_pin[0] = i[1]; mc_tick = 1'b1; cyc(); mc_tick = 1'b0; cyc();
        end
        cnt_pin[0] = 1'b1; cyc(); cnt_pin[0] = 1'b0; cyc(); cyc();

        tag = "R4";
        wr_cfg(8'h0D);
        gate_pin[0] = 1'b0; ticks(3);
        gate_pin[0] = 1'b1; wr_cfg(8'h09); ticks(3);
        wr_ctl(4'b0000); ticks(2);

        tag = "R5";
        wr_cfg(8'h00); wr_cnt(2'd1, 8'hFF); wr_cnt(2'd0, 8'hFC); wr_ctl(4'b0001);
        ticks(6);

        tag = "R6";
        wr_ctl(4'b0001); wr_cfg(8'h01); wr_cnt(2'd0, 8'hFE); wr_cnt(2'd1, 8'hFF);
        ticks(4);

        tag = "R7";
        wr_ctl(4'b0001); wr_cfg(8'h02); wr_cnt(2'd1, 8'h80); wr_cnt(2'd0, 8'hFE);
        ticks(5);

        tag = "R8";
        wr_ctl(4'b0011); wr_cfg(8'h0F); gate_pin = 2'b00;
        wr_cnt(2'd0, 8'hFE); wr_cnt(2'd1, 8'hFD);
        ticks(5);

        tag = "R9";
        wr_cfg(8'h13); wr_cnt(2'd2, 8'hFF); wr_cnt(2'd3, 8'hFF); wr_ctl(4'b0011);
        ticks(4);
        wr_cfg(8'h31); ticks(4);

        tag = "R10";
        wr_cfg(8'h11); wr_ctl(4'b0011);
        for (int i = 0; i < 4; i++) begin
            cnt_we = 1'b1; cnt_sel = 2'(i); cnt_wdata = 8'(8'h30 + i);
            mc_tick = 1'b1; cyc();
        end
        mc_tick = 1'b0; cyc();

        tag = "R11";
        wr_cfg(8'h01); wr_cnt(2'd0, 8'hFF); wr_cnt(2'd1, 8'hFF); wr_ctl(4'b1101);
        mc_tick = 1'b1; ctl_we = 1'b1; ctl_wdata = 4'b0001; cyc();
        mc_tick = 1'b0; wr_ctl(4'b0001); wr_ctl(4'b1100);

        for (int i = 0; i < 4000; i++) begin
            tag = mode_tag(m_cfg[1:0]);
            mc_tick  = ($urandom % 2) == 0;
            cnt_pin  = 2'($urandom);
            gate_pin = 2'($urandom);
            if ($urandom % 40 == 0) begin cfg_we = 1'b1; cfg_wdata = 8'($urandom); end
            if ($urandom % 25 == 0) begin ctl_we = 1'b1; ctl_wdata = 4'($urandom) | 4'b0011; end
            if ($urandom % 15 == 0) begin
                cnt_we = 1'b1; cnt_sel = 2'($urandom);
                cnt_wdata = ($urandom % 2) ? 8'hFE : 8'($urandom);
            end
            cyc();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule